// File: doc/BRIEF.md
# Two-Channel UART Register Front-End

This block is the host-facing register file for a pair of UART channels that share one interrupt request line. A host issues single-cycle byte reads and writes over a simple select/write-enable bus. The block turns each access into data, interrupt-enable, interrupt-identification and line-status operations on channel A or channel B. There is no serial engine here. A transmit is a byte presented on an output with a one-cycle strobe. A receive is a byte delivered on an input with a valid pulse, and it is held in a one-byte slot until the host reads it.

The interrupt is a level output held in a register. A receive-ready or transmit-ready event on an enabled channel sets it. Any access to channel A's identification register clears it. An external periodic tick drives a divider, and on every second tick channel A gets a synthetic transmit-ready event. This lets the host drain transmit output with no transmitter behind it. Channel B never gets that event. A parameter sets the register spacing: the bus address is shifted right by it before decoding, so the same block can sit behind byte-, half-word- or word-strided address maps.

Top module: `twin_uart_regs`

## Requirements
- R1: The decoded offset is `bus_addr >> SPACING`. Offsets 0..7 address channel A and 8..15 address channel B. Within a channel, the low three bits select the register: 0 is data, 1 is interrupt enable, 2 is identification, 5 is status. Read data appears on `bus_rdata` in the cycle after the access and is 0x00 in cycles that follow no read.
- R2: A data write drives the byte on that channel's `tx_data_*` with `tx_strobe_*` high for one cycle after the access. It sets the channel's sticky transmit-done flag, and it raises `irq` if enable bit 1 of that channel is set.
- R3: A data read returns the byte in the receive slot and marks the slot empty.
- R4: The enable register is 8-bit read/write; bit 0 enables receive-ready and bit 1 transmit-ready. A write with bit 1 clear pulses `tx_flush_*` for one cycle after the access.
- R5: An identification read returns 0x04 while a received byte waits. Otherwise it returns 0x02 if the transmit-done flag is set, and clears the flag. Otherwise it returns 0x01.
- R6: Any access, read or write, to offset 2 deasserts `irq` on the next cycle. An access to offset 10 leaves it unchanged. A set event in the same cycle takes precedence over the clear.
- R7: A status read returns 0x60, ORed with 0x01 when a received byte waits.
- R8: A `rx_valid_*` pulse loads the slot, overwriting any unread byte. It raises `irq` if enable bit 0 was set before that cycle. An arrival in the same cycle as a data read leaves the new byte waiting.
- R9: On every second `tick` pulse since reset, if channel A's enable bit 1 is set, channel A's transmit-done flag is set and `irq` is raised. Channel B never gets this event.
- R10: Reads of offsets 3, 4, 6, 7, 11, 12, 14, 15 and 16 and above return 0x00, and writes to them change nothing.
- R11: Reset clears both enable registers, both transmit-done flags, both receive slots, the tick divider, `irq` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address before spacing shift |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_data_a | output | 8 | Channel A transmit byte |
| tx_strobe_a | output | 1 | Channel A transmit strobe |
| tx_flush_a | output | 1 | Channel A flush request |
| tx_data_b | output | 8 | Channel B transmit byte |
| tx_strobe_b | output | 1 | Channel B transmit strobe |
| tx_flush_b | output | 1 | Channel B flush request |
| rx_data_a | input | 8 | Channel A received byte |
| rx_valid_a | input | 1 | Channel A byte valid |
| rx_data_b | input | 8 | Channel B received byte |
| rx_valid_b | input | 1 | Channel B byte valid |
| tick | input | 1 | Periodic tick pulse |
| irq | output | 1 | Shared level interrupt |

## Verification
The bench goes after the identification priority. A design that ranked transmit above receive, or cleared the transmit-done flag while a byte waited, would lose a later 0x02. It checks the asymmetric clear: clearing on offset 10, or only on reads, would drop or keep `irq` at the wrong time. It covers an arrival in the same cycle as a data read, where dropping the new byte would make status bit 0 read zero. It covers tick parity, where firing on every tick or on channel B would raise spurious interrupts.

// File: rtl/twin_uart_pkg.sv
package twin_uart_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [2:0] IDX_DATA = 3'd0;
  localparam logic [2:0] IDX_IEN  = 3'd1;
  localparam logic [2:0] IDX_IDENT = 3'd2;
  localparam logic [2:0] IDX_STAT = 3'd5;

  localparam logic [BYTE_W-1:0] IDENT_RX   = 8'h04;
  localparam logic [BYTE_W-1:0] IDENT_TX   = 8'h02;
  localparam logic [BYTE_W-1:0] IDENT_NONE = 8'h01;
  localparam logic [BYTE_W-1:0] STAT_IDLE  = 8'h60;

  typedef struct packed {
    logic rd_data;
    logic wr_data;
    logic rd_ien;
    logic wr_ien;
    logic rd_ident;
    logic rd_stat;
  } chan_op_t;
endpackage

// File: rtl/twin_uart_tick.sv
module twin_uart_tick #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic evt
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign evt = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_chk
      assert_tick_alternate_R9: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);
    end
  endgenerate
endmodule

// File: rtl/twin_uart_chan.sv
module twin_uart_chan
  import twin_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  chan_op_t          op,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              synth_tx,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_strobe,
  output logic              tx_flush,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              irq_set
);
  logic [BYTE_W-1:0] ien;
  logic              tx_done;
  logic              rx_full;
  logic [BYTE_W-1:0] rx_hold;
  logic              tx_evt;

  assign tx_evt  = op.wr_data || (synth_tx && ien[1]);
  assign irq_set = (op.wr_data && ien[1]) || (rx_valid && ien[0]) || (synth_tx && ien[1]);

  always_comb begin
    rd_byte = '0;
    if (op.rd_data) rd_byte = rx_hold;
    else if (op.rd_ien) rd_byte = ien;
    else if (op.rd_ident) rd_byte = rx_full ? IDENT_RX : (tx_done ? IDENT_TX : IDENT_NONE);
    else if (op.rd_stat) rd_byte = STAT_IDLE | {{(BYTE_W-1){1'b0}}, rx_full};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien       <= '0;
      tx_done   <= 1'b0;
      rx_full   <= 1'b0;
      rx_hold   <= '0;
      tx_byte   <= '0;
      tx_strobe <= 1'b0;
      tx_flush  <= 1'b0;
    end else begin
      tx_strobe <= op.wr_data;
      tx_flush  <= op.wr_ien && !wdata[1];
      if (op.wr_data) tx_byte <= wdata;
      if (op.wr_ien) ien <= wdata;
      if (tx_evt) tx_done <= 1'b1;
      else if (op.rd_ident && !rx_full) tx_done <= 1'b0;
      if (rx_valid) begin
        rx_full <= 1'b1;
        rx_hold <= rx_byte;
      end else if (op.rd_data) begin
        rx_full <= 1'b0;
      end
    end
  end

  assert_tx_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    op.wr_data |=> tx_strobe && (tx_byte == $past(wdata)));
  assert_flush_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (op.wr_ien && !wdata[1]) |=> tx_flush);
  assert_ident_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (op.rd_ident && !rx_full && !tx_evt) |=> !tx_done);
  assert_rx_load_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> rx_full && (rx_hold == $past(rx_byte)));
endmodule

// File: rtl/twin_uart_regs.sv
module twin_uart_regs
  import twin_uart_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SPACING  = 0,
  parameter int unsigned TICK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        tx_data_a,
  output logic              tx_strobe_a,
  output logic              tx_flush_a,
  output logic [7:0]        tx_data_b,
  output logic              tx_strobe_b,
  output logic              tx_flush_b,
  input  logic [7:0]        rx_data_a,
  input  logic              rx_valid_a,
  input  logic [7:0]        rx_data_b,
  input  logic              rx_valid_b,
  input  logic              tick,
  output logic              irq
);
  localparam int unsigned NCH = 2;

  logic [ADDR_W-1:0] off;
  logic              in_map;
  logic              ch_b;
  logic [2:0]        idx;
  logic              ident_a_hit;
  logic              tick_evt;

  logic [BYTE_W-1:0] rx_byte_v [NCH];
  logic              rx_valid_v [NCH];
  logic [BYTE_W-1:0] tx_byte_v [NCH];
  logic              tx_strobe_v [NCH];
  logic              tx_flush_v [NCH];
  logic [BYTE_W-1:0] rd_byte_v [NCH];
  logic [NCH-1:0]    set_v;
  chan_op_t          op_v [NCH];

  assign off         = bus_addr >> SPACING;
  assign in_map      = (off >> 4) == '0;
  assign ch_b        = off[3];
  assign idx         = off[2:0];
  assign ident_a_hit = bus_sel && in_map && (off[3:0] == 4'd2);

  assign rx_byte_v[0]  = rx_data_a;
  assign rx_byte_v[1]  = rx_data_b;
  assign rx_valid_v[0] = rx_valid_a;
  assign rx_valid_v[1] = rx_valid_b;

  twin_uart_tick #(.DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .evt (tick_evt)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      assign hit = bus_sel && in_map && (ch_b == (c == 1));
      always_comb begin
        op_v[c]          = '0;
        op_v[c].rd_data  = hit && !bus_we && (idx == IDX_DATA);
        op_v[c].wr_data  = hit &&  bus_we && (idx == IDX_DATA);
        op_v[c].rd_ien   = hit && !bus_we && (idx == IDX_IEN);
        op_v[c].wr_ien   = hit &&  bus_we && (idx == IDX_IEN);
        op_v[c].rd_ident = hit && !bus_we && (idx == IDX_IDENT);
        op_v[c].rd_stat  = hit && !bus_we && (idx == IDX_STAT);
      end
      twin_uart_chan u_chan (
        .clk      (clk),
        .rst      (rst),
        .op       (op_v[c]),
        .wdata    (bus_wdata),
        .rx_valid (rx_valid_v[c]),
        .rx_byte  (rx_byte_v[c]),
        .synth_tx ((c == 0) ? tick_evt : 1'b0),
        .tx_byte  (tx_byte_v[c]),
        .tx_strobe(tx_strobe_v[c]),
        .tx_flush (tx_flush_v[c]),
        .rd_byte  (rd_byte_v[c]),
        .irq_set  (set_v[c])
      );
    end
  endgenerate

  assign tx_data_a   = tx_byte_v[0];
  assign tx_strobe_a = tx_strobe_v[0];
  assign tx_flush_a  = tx_flush_v[0];
  assign tx_data_b   = tx_byte_v[1];
  assign tx_strobe_b = tx_strobe_v[1];
  assign tx_flush_b  = tx_flush_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (|set_v) irq <= 1'b1;
      else if (ident_a_hit) irq <= 1'b0;
      bus_rdata <= (bus_sel && !bus_we && in_map) ? rd_byte_v[ch_b] : '0;
    end
  end

  assert_irq_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (ident_a_hit && !(|set_v)) |=> !irq);
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (|set_v) |=> irq);
  assert_idle_rdata_R1: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> (bus_rdata == '0));
  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!ident_a_hit && !(|set_v)) |=> $stable(irq));
endmodule

// File: tb/twin_uart_regs_tb.sv
module twin_uart_regs_tb;
  localparam int SP = 2;
  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_we = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic [7:0] tx_data_a, tx_data_b, rx_data_a = 0, rx_data_b = 0;
  logic tx_strobe_a, tx_flush_a, tx_strobe_b, tx_flush_b;
  logic rx_valid_a = 0, rx_valid_b = 0, tick = 0, irq;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  twin_uart_regs #(.ADDR_W(8), .SPACING(SP), .TICK_DIV(2)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data_a(tx_data_a), .tx_strobe_a(tx_strobe_a), .tx_flush_a(tx_flush_a),
    .tx_data_b(tx_data_b), .tx_strobe_b(tx_strobe_b), .tx_flush_b(tx_flush_b),
    .rx_data_a(rx_data_a), .rx_valid_a(rx_valid_a),
    .rx_data_b(rx_data_b), .rx_valid_b(rx_valid_b), .tick(tick), .irq(irq));

  // bench model
  logic [7:0] m_ien [2];
  logic       m_txd [2];
  logic       m_rxf [2];
  logic [7:0] m_rxb [2];
  logic       m_cnt, m_irq;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic string reg_tag(input int o);
    if (o >= 16) return "R10";
    case (o % 8)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      5: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [7:0] model_read(input int o);
    int c;
    if (o >= 16) return 8'h00;
    c = o / 8;
    case (o % 8)
      0: return m_rxb[c];
      1: return m_ien[c];
      2: return m_rxf[c] ? 8'h04 : (m_txd[c] ? 8'h02 : 8'h01);
      5: return 8'h60 | {7'd0, m_rxf[c]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_ien[c] = 0; m_txd[c] = 0; m_rxf[c] = 0; m_rxb[c] = 0;
    end
    m_cnt = 0; m_irq = 0;
  endtask

  // one bus cycle with side inputs; checks outputs after the edge
  task automatic step(input logic sel, input logic we, input int o, input logic [7:0] wd,
                      input logic va, input logic [7:0] da, input logic vb,
                      input logic [7:0] db, input logic tk);
    logic [7:0] exp_rd;
    logic set, evt, rd;
    logic [1:0] exp_stb, exp_fl;
    logic [7:0] rx_d [2];
    logic rx_v [2];
    int c, idx;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = 8'(o << SP); bus_wdata = wd;
    rx_valid_a = va; rx_data_a = da; rx_valid_b = vb; rx_data_b = db; tick = tk;
    rx_d[0] = da; rx_d[1] = db; rx_v[0] = va; rx_v[1] = vb;
    rd = sel && !we;
    exp_rd = rd ? model_read(o) : 8'h00;
    c = (o / 8) % 2; idx = o % 8;
    evt = tk && m_cnt;
    if (tk) m_cnt = !m_cnt;
    set = 0; exp_stb = 0; exp_fl = 0;
    for (int k = 0; k < 2; k++) begin
      logic hit, synth;
      hit = sel && o < 16 && c == k;
      synth = (k == 0) && evt && m_ien[k][1];
      if ((hit && we && idx == 0 && m_ien[k][1]) || (rx_v[k] && m_ien[k][0]) || synth) set = 1;
      if ((hit && we && idx == 0) || synth) m_txd[k] = 1;
      else if (hit && rd && idx == 2 && !m_rxf[k]) m_txd[k] = 0;
      if (rx_v[k]) begin m_rxf[k] = 1; m_rxb[k] = rx_d[k]; end
      else if (hit && rd && idx == 0) m_rxf[k] = 0;
      if (hit && we && idx == 0) exp_stb[k] = 1;
      if (hit && we && idx == 1) begin m_ien[k] = wd; exp_fl[k] = !wd[1]; end
    end
    if (set) m_irq = 1;
    else if (sel && o == 2) m_irq = 0;
    @(posedge clk); #1;
    chk({7'd0, irq}, {7'd0, m_irq}, "R6/R8/R9 irq");
    chk(bus_rdata, exp_rd, rd ? reg_tag(o) : "R1 idle rdata");
    chk({6'd0, tx_strobe_b, tx_strobe_a}, {6'd0, exp_stb}, "R2 strobe");
    chk({6'd0, tx_flush_b, tx_flush_a}, {6'd0, exp_fl}, "R4 flush");
    if (exp_stb[0]) chk(tx_data_a, wd, "R2 tx_data_a");
    if (exp_stb[1]) chk(tx_data_b, wd, "R2 tx_data_b");
  endtask

  task automatic rd_(input int o);  step(1, 0, o, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr_(input int o, input logic [7:0] d); step(1, 1, o, d, 0, 0, 0, 0, 0); endtask
  task automatic idle_(input logic tk); step(0, 0, 0, 0, 0, 0, 0, 0, tk); endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R11 reset state
    chk({7'd0, irq}, 8'h00, "R11 irq");
    chk(bus_rdata, 8'h00, "R11 rdata");
    rd_(1); rd_(9); rd_(2); rd_(13); rd_(0);
    // R2 write without enable: no irq, flag set; R5 ident then clears
    wr_(0, 8'h41); rd_(2); rd_(2);
    // R4 enable with bit1, R2 irq on write, R6 B ident does not clear, A ident does
    wr_(1, 8'h03); wr_(0, 8'h5a); rd_(10); wr_(2, 8'h00);
    // R5 priority: rx waiting hides tx-done, flag survives
    wr_(0, 8'h11); step(0, 0, 0, 0, 1, 8'hc3, 0, 0, 0);
    rd_(2); rd_(5); rd_(0); rd_(5); rd_(2); rd_(2);
    // R8 overwrite and same-cycle arrival with read (R3)
    step(0, 0, 0, 0, 1, 8'h01, 0, 0, 0); step(0, 0, 0, 0, 1, 8'h02, 0, 0, 0);
    step(1, 0, 0, 0, 1, 8'h03, 0, 0, 0); rd_(5); rd_(0); rd_(5);
    // R1 channel B and R8 B arrival with enable
    wr_(9, 8'h01); step(0, 0, 0, 0, 0, 0, 1, 8'h77, 0); rd_(13); rd_(10); rd_(8); rd_(2);
    // R9 tick parity: A enabled, B enabled, then A disabled
    wr_(9, 8'h02); wr_(1, 8'h02);
    idle_(1); idle_(0); idle_(1); rd_(2); rd_(10); idle_(1); idle_(1); rd_(2);
    wr_(1, 8'h00); idle_(1); idle_(1); rd_(2);
    // R10 undecoded
    wr_(3, 8'hff); wr_(12, 8'hff); wr_(20, 8'hff); rd_(3); rd_(6); rd_(15); rd_(30); rd_(1); rd_(9);
    // random mix, fixed seed
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < 4000; i++) begin
      int o;
      o = ($urandom % 8 == 0) ? int'($urandom % 40) : int'($urandom % 16);
      step(($urandom % 10) < 7, $urandom % 2, o, 8'($urandom),
           ($urandom % 8) == 0, 8'($urandom), ($urandom % 8) == 0, 8'($urandom),
           ($urandom % 3) == 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule